// File: doc/BRIEF.md
# Dual-Pointer Flag Offset Access Port

This block holds the two threshold offsets that a FIFO's partial flags are compared against: one for the almost-empty flag and one for the almost-full flag. Both offsets are loaded and read back over the FIFO's ordinary data buses. When the load strobe is low, a qualified write on the write clock puts the input word into an offset register instead of the FIFO. A qualified read on the read clock puts an offset onto the registered output bus.

A one-bit slot pointer on each side picks the register for the next access. Each pointer starts at the almost-empty slot and flips after every qualified access, so the registers are visited in the order empty, full, empty, and so on. The write pointer and the read pointer move on their own. A master reset returns the offsets, the pointers and the validity bits to their starting state. A partial reset only clears the output bus.

Each offset has a validity bit that the flag logic downstream uses to know when its threshold can be trusted. The offset values and the validity bits are presented continuously as outputs.

Top module: `flag_offset_port`

## Requirements
- R1: When `ld_n`=0 and `wen_n`=0 at a rising `wr_clk` edge, `wdata` is stored in the slot the write pointer selects, and the pointer then moves to the other slot. The slots are visited in the order almost-empty, almost-full, almost-empty.
- R2: When `ld_n`=0 and `ren_n`=0 at a rising `rd_clk` edge, `rdata` takes the value of the slot the read pointer selects, and the read pointer then moves to the other slot. The order is almost-empty, almost-full, almost-empty.
- R3: The write pointer and the read pointer advance independently. Writes do not move the read pointer, and reads do not move the write pointer.
- R4: A master reset (`mrst_n`=0) does four things: it puts both pointers on the almost-empty slot, loads both offsets with `RESET_OFFSET` (default 7), clears both validity bits, and clears `rdata` to 0.
- R5: A partial reset (`prst_n`=0) clears `rdata` to 0. It leaves both pointers, both offsets and both validity bits unchanged.
- R6: A write-clock edge with `ld_n`=1 or `wen_n`=1 stores nothing and does not move the write pointer. The next qualified write goes to the slot that follows the last slot written.
- R7: A read-clock edge with `ld_n`=1 or `ren_n`=1 leaves `rdata` and the read pointer unchanged. The next qualified read continues the sequence where it stopped.
- R8: A write to the almost-empty slot sets `ae_offset_vld` and clears `af_offset_vld`, which marks the start of a new programming pass. A write to the almost-full slot sets `af_offset_vld`.
- R9: `rdata` is a register on `rd_clk`. It changes only on the edge that follows a qualified read, or on a partial or master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, clears the output bus only |
| ld_n | input | 1 | Load strobe, active low, steers accesses to the offset registers |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | W | Offset value to store |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | W | Registered output bus carrying read-back offsets |
| ae_offset | output | W | Current almost-empty offset |
| af_offset | output | W | Current almost-full offset |
| ae_offset_vld | output | 1 | Almost-empty offset has been written in this pass |
| af_offset_vld | output | 1 | Almost-full offset has been written in this pass |

## Verification
The assertions assume that `ld_n`, `wen_n`, `ren_n` and `wdata` are stable around each clock edge that samples them. They also assume that an offset read and an offset write never happen at the same moment, because the read side samples the offset registers without synchronisation. The bench meets both assumptions. It changes inputs only on the falling edge of the clock that samples them, and it runs write sequences and read sequences one after the other, never overlapping. Resets are asserted away from the clock edges and held for whole cycles, so each synchronised release happens on a clean edge.

// File: rtl/fop_pkg.sv
package fop_pkg;
  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } slot_e;

  function automatic slot_e next_slot(slot_e s);
    return (s == SLOT_AE) ? SLOT_AF : SLOT_AE;
  endfunction
endpackage

// File: rtl/fop_rst_sync.sv
module fop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fop_wr_side.sv
module fop_wr_side
  import fop_pkg::*;
#(
  parameter int           W            = 16,
  parameter logic [W-1:0] RESET_OFFSET = W'(7)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic         wen_n,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ae_off,
  output logic [W-1:0] af_off,
  output logic         ae_vld,
  output logic         af_vld
);
  slot_e        wptr_q, wptr_d;
  logic [W-1:0] ae_q, ae_d, af_q, af_d;
  logic         aev_q, aev_d, afv_q, afv_d;
  logic         wr_fire;

  assign wr_fire = !ld_n && !wen_n;

  always_comb begin
    wptr_d = wptr_q;
    ae_d   = ae_q;
    af_d   = af_q;
    aev_d  = aev_q;
    afv_d  = afv_q;
    if (wr_fire) begin
      wptr_d = next_slot(wptr_q);
      if (wptr_q == SLOT_AE) begin
        ae_d  = wdata;
        aev_d = 1'b1;
        afv_d = 1'b0;
      end else begin
        af_d  = wdata;
        afv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= SLOT_AE;
      ae_q   <= RESET_OFFSET;
      af_q   <= RESET_OFFSET;
      aev_q  <= 1'b0;
      afv_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
      aev_q  <= aev_d;
      afv_q  <= afv_d;
    end
  end

  assign ae_off = ae_q;
  assign af_off = af_q;
  assign ae_vld = aev_q;
  assign af_vld = afv_q;

  a_r1_ae_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wptr_q == SLOT_AE) |=> (ae_off == $past(wdata) && $stable(af_off)));
  a_r1_af_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wptr_q == SLOT_AF) |=> (af_off == $past(wdata) && $stable(ae_off)));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(ae_off) && $stable(af_off) && $stable(wptr_q) && $stable(ae_vld) && $stable(af_vld)));
  a_r8_pass_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wptr_q == SLOT_AE) |=> (ae_vld && !af_vld));
  a_r8_af_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wptr_q == SLOT_AF) |=> af_vld);
endmodule

// File: rtl/fop_rd_side.sv
module fop_rd_side
  import fop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rst_n,
  input  logic         ld_n,
  input  logic         ren_n,
  input  logic [W-1:0] ae_off,
  input  logic [W-1:0] af_off,
  output logic [W-1:0] rdata
);
  slot_e        rptr_q, rptr_d;
  logic [W-1:0] bus_q, bus_d;
  logic         rd_fire;

  assign rd_fire = !ld_n && !ren_n;

  always_comb begin
    rptr_d = rptr_q;
    bus_d  = bus_q;
    if (rd_fire) begin
      rptr_d = next_slot(rptr_q);
      bus_d  = (rptr_q == SLOT_AE) ? ae_off : af_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr_q <= SLOT_AE;
    else        rptr_q <= rptr_d;
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) bus_q <= '0;
    else            bus_q <= bus_d;
  end

  assign rdata = bus_q;

  a_r2_ae_read: assert property (@(posedge clk) disable iff (!bus_rst_n || !rst_n)
    (rd_fire && rptr_q == SLOT_AE) |=> (rdata == $past(ae_off)));
  a_r2_af_read: assert property (@(posedge clk) disable iff (!bus_rst_n || !rst_n)
    (rd_fire && rptr_q == SLOT_AF) |=> (rdata == $past(af_off)));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!bus_rst_n || !rst_n)
    !rd_fire |=> ($stable(rdata) && $stable(rptr_q)));
endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port #(
  parameter int           W            = 16,
  parameter int           SYNC_STAGES  = 2,
  parameter logic [W-1:0] RESET_OFFSET = W'(7)
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         ld_n,
  input  logic         wen_n,
  input  logic [W-1:0] wdata,
  input  logic         ren_n,
  output logic [W-1:0] rdata,
  output logic [W-1:0] ae_offset,
  output logic [W-1:0] af_offset,
  output logic         ae_offset_vld,
  output logic         af_offset_vld
);
  logic wr_rst_n, rd_rst_n, rd_prst_n, bus_rst_n;

  fop_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(mrst_n), .srst_n(wr_rst_n));
  fop_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(mrst_n), .srst_n(rd_rst_n));
  fop_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_prst (
    .clk(rd_clk), .arst_n(prst_n), .srst_n(rd_prst_n));

  assign bus_rst_n = rd_rst_n & rd_prst_n;

  fop_wr_side #(.W(W), .RESET_OFFSET(RESET_OFFSET)) u_wr (
    .clk    (wr_clk),
    .rst_n  (wr_rst_n),
    .ld_n   (ld_n),
    .wen_n  (wen_n),
    .wdata  (wdata),
    .ae_off (ae_offset),
    .af_off (af_offset),
    .ae_vld (ae_offset_vld),
    .af_vld (af_offset_vld)
  );

  fop_rd_side #(.W(W)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .bus_rst_n (bus_rst_n),
    .ld_n      (ld_n),
    .ren_n     (ren_n),
    .ae_off    (ae_offset),
    .af_off    (af_offset),
    .rdata     (rdata)
  );

  a_r4_reset_state: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(wr_rst_n) |-> (!ae_offset_vld && !af_offset_vld && ae_offset == RESET_OFFSET && af_offset == RESET_OFFSET));
endmodule

// File: tb/flag_offset_port_bench.sv
module flag_offset_port_bench;
  localparam int W = 16;
  localparam logic [W-1:0] RST_OFF = 16'd7;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, ae_offset, af_offset;
  logic ae_offset_vld, af_offset_vld;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 wr_clk = ~wr_clk;
  initial begin #5; forever #10 rd_clk = ~rd_clk; end

  flag_offset_port #(.W(W), .RESET_OFFSET(RST_OFF)) u_flag_offset_port (
    .wr_clk, .rd_clk, .mrst_n, .prst_n, .ld_n, .wen_n, .wdata, .ren_n,
    .rdata, .ae_offset, .af_offset, .ae_offset_vld, .af_offset_vld);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(logic ld, logic we, logic [W-1:0] d);
    @(negedge wr_clk); ld_n = ld; wen_n = we; wdata = d;
    @(negedge wr_clk); ld_n = 1'b1; wen_n = 1'b1;
  endtask

  task automatic rd_op(logic ld, logic re);
    @(negedge rd_clk); ld_n = ld; ren_n = re;
    @(negedge rd_clk); ld_n = 1'b1; ren_n = 1'b1;
  endtask

  task automatic do_mreset();
    @(negedge wr_clk); mrst_n = 1'b0;
    repeat (2) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    chk("R4 ae offset after reset", ae_offset, RST_OFF);
    chk("R4 af offset after reset", af_offset, RST_OFF);
    chk("R4 ae valid after reset", 16'(ae_offset_vld), 16'd0);
    chk("R4 af valid after reset", 16'(af_offset_vld), 16'd0);
    chk("R4 rdata after reset", rdata, 16'd0);
  endtask

  task automatic t_write_seq();
    wr_op(1'b0, 1'b0, 16'h0A11);
    chk("R1 first write to ae", ae_offset, 16'h0A11);
    chk("R8 ae valid set", 16'(ae_offset_vld), 16'd1);
    chk("R8 af valid still clear", 16'(af_offset_vld), 16'd0);
    wr_op(1'b0, 1'b0, 16'h0B22);
    chk("R1 second write to af", af_offset, 16'h0B22);
    chk("R8 af valid set", 16'(af_offset_vld), 16'd1);
    wr_op(1'b0, 1'b0, 16'h0C33);
    chk("R1 third write back to ae", ae_offset, 16'h0C33);
    chk("R1 af kept", af_offset, 16'h0B22);
    chk("R8 new pass clears af valid", 16'(af_offset_vld), 16'd0);
  endtask

  task automatic t_read_seq();
    rd_op(1'b0, 1'b0);
    chk("R3 read starts at ae despite write pointer", rdata, 16'h0C33);
    rd_op(1'b0, 1'b0);
    chk("R2 second read gives af", rdata, 16'h0B22);
    rd_op(1'b0, 1'b0);
    chk("R2 third read back to ae", rdata, 16'h0C33);
  endtask

  task automatic t_wr_suspend();
    wr_op(1'b1, 1'b0, 16'hDEAD);
    chk("R6 ld high: ae unchanged", ae_offset, 16'h0C33);
    chk("R6 ld high: af unchanged", af_offset, 16'h0B22);
    wr_op(1'b0, 1'b1, 16'hBEEF);
    chk("R6 wen high: af unchanged", af_offset, 16'h0B22);
    chk("R6 wen high: ae unchanged", ae_offset, 16'h0C33);
    wr_op(1'b0, 1'b0, 16'h0E55);
    chk("R6 resumed write goes to af", af_offset, 16'h0E55);
    chk("R6 resumed write keeps ae", ae_offset, 16'h0C33);
  endtask

  task automatic t_rd_suspend();
    rd_op(1'b1, 1'b0);
    chk("R7 ld high: rdata held", rdata, 16'h0C33);
    rd_op(1'b0, 1'b1);
    chk("R9 ren high: rdata held", rdata, 16'h0C33);
    rd_op(1'b0, 1'b0);
    chk("R7 resumed read gives af", rdata, 16'h0E55);
  endtask

  task automatic t_partial();
    @(negedge rd_clk); prst_n = 1'b0;
    @(negedge rd_clk);
    chk("R5 partial reset clears rdata", rdata, 16'd0);
    chk("R5 partial reset keeps ae", ae_offset, 16'h0C33);
    chk("R5 partial reset keeps af", af_offset, 16'h0E55);
    chk("R5 partial reset keeps af valid", 16'(af_offset_vld), 16'd1);
    prst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    rd_op(1'b0, 1'b0);
    chk("R5 read pointer kept (ae next)", rdata, 16'h0C33);
    wr_op(1'b0, 1'b0, 16'h0F66);
    chk("R5 write pointer kept (ae next)", ae_offset, 16'h0F66);
  endtask

  task automatic t_master();
    do_mreset();
    t_reset();
    wr_op(1'b0, 1'b0, 16'h1177);
    chk("R4 write pointer back at ae", ae_offset, 16'h1177);
    chk("R4 af untouched by write", af_offset, RST_OFF);
    rd_op(1'b0, 1'b0);
    chk("R4 read pointer back at ae", rdata, 16'h1177);
  endtask

  initial begin
    do_mreset();
    t_reset();
    t_write_seq();
    t_read_seq();
    t_wr_suspend();
    t_rd_suspend();
    t_partial();
    t_master();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule